// File: doc/BRIEF.md
# Multi-Word Register Freshness Tracker

This block follows the update state of a wide register, such as a key or an initialisation vector, that software fills one word per bus write. It watches one write-enable bit per word, a consume pulse and a wipe pulse. It reports two flags. The fresh flag means every word has been rewritten since the value was last consumed or wiped. The consistent flag means the register holds a whole value and not a blend of old and new words. The storage itself and the bus decode sit outside the block.

A controller that must only start work on a complete value waits for the consistent flag. A controller that must never reuse a value also waits for the fresh flag, and pulses the consume input when it takes the value. Both flags are registered. Each one reflects the inputs of the previous clock cycle.

Top module: `fresh_track`

## Requirements
- R1: While reset is applied and in the first cycle after it, `fresh_o` and `consistent_o` are both 0.
- R2: When every word has been marked as written since the last consume or wipe, counting the marks of the current cycle, then in the next cycle `fresh_o` and `consistent_o` are both 1 and the per-word marks are emptied. A cycle with all bits of `word_we_i` set does this on its own.
- R3: A cycle that leaves some words marked but not all makes `fresh_o` and `consistent_o` 0 in the next cycle.
- R4: Once a partial update is pending, `consistent_o` stays 0 until the remaining words are written. The words may be written in any order, and a word may be written more than once.
- R5: A consume pulse (`use_i`=1) with no write enables gives `fresh_o`=0 in the next cycle and leaves `consistent_o` unchanged.
- R6: A consume pulse discards the pending word marks. Write enables in the same cycle are recorded after the consume, so they count towards the next complete update.
- R7: A wipe pulse (`clear_i`=1) gives `consistent_o`=1 and `fresh_o`=0 in the next cycle and discards all pending marks. The wipe takes priority over a consume and over write enables in the same cycle.
- R8: A cycle with no write enable, no consume and no wipe leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| word_we_i | input | WORDS | One write-enable bit per register word |
| use_i | input | 1 | Consume pulse: the current value was taken |
| clear_i | input | 1 | Wipe pulse: the register contents were erased |
| fresh_o | output | 1 | Every word was rewritten since the last consume or wipe |
| consistent_o | output | 1 | The register holds a whole, unmixed value |

## Verification
The hardest case to reach is a consume or a wipe that lands while a partial update is pending, in the same cycle as further write enables. In that case the order of discard and record decides which words still count. Directed sequences build up partial marks word by word and then hit these collisions. The random phase draws sparse single-word and few-word enables, so that partial states last over many cycles. Consume and wipe pulses arrive at a low rate among them.

// File: rtl/fresh_track_pkg.sv
package fresh_track_pkg;

  typedef struct packed {
    logic fresh;
    logic consistent;
  } flag_pair_t;

  localparam flag_pair_t FlagsReset = '{fresh: 1'b0, consistent: 1'b0};
  localparam flag_pair_t FlagsWiped = '{fresh: 1'b0, consistent: 1'b1};
  localparam flag_pair_t FlagsFull  = '{fresh: 1'b1, consistent: 1'b1};

endpackage

// File: rtl/fresh_track_marks.sv
module fresh_track_marks #(
  parameter int unsigned WORDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WORDS-1:0] word_we_i,
  input  logic             use_i,
  input  logic             clear_i,
  output logic             all_marked_o,
  output logic             some_marked_o
);

  logic [WORDS-1:0] mark_q;
  logic [WORDS-1:0] mark_d;
  logic [WORDS-1:0] merged;
  logic             complete;

  // Per word: a consume drops the old mark first, then this cycle's write is added.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign merged[w] = (mark_q[w] & ~use_i) | word_we_i[w];
  end

  assign complete = &merged;

  always_comb begin
    mark_d = merged;
    if (clear_i || complete) begin
      mark_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_q <= '0;
    end else begin
      mark_q <= mark_d;
    end
  end

  assign all_marked_o  = complete & ~clear_i;
  assign some_marked_o = (|merged) & ~complete & ~clear_i;

  a_r2_marks_emptied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_marked_o |=> (mark_q == '0));
  a_r7_marks_wiped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (mark_q == '0));
  a_r6_use_keeps_new_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && !clear_i && !all_marked_o) |=> (mark_q == $past(word_we_i)));

endmodule

// File: rtl/fresh_track_flags.sv
module fresh_track_flags
  import fresh_track_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic use_i,
  input  logic all_marked_i,
  input  logic some_marked_i,
  output logic fresh_o,
  output logic consistent_o
);

  flag_pair_t flags_q;
  flag_pair_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (clear_i) begin
      flags_d = FlagsWiped;
    end else if (all_marked_i) begin
      flags_d = FlagsFull;
    end else if (some_marked_i) begin
      flags_d = FlagsReset;
    end else if (use_i) begin
      flags_d.fresh = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= FlagsReset;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign fresh_o      = flags_q.fresh;
  assign consistent_o = flags_q.consistent;

  a_r3_partial_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    some_marked_i |=> (!fresh_o && !consistent_o));
  a_r5_use_drops_fresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_i && !clear_i && !all_marked_i && !some_marked_i) |=>
      (!fresh_o && $stable(consistent_o)));
  a_r7_wipe_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (consistent_o && !fresh_o));
  a_r2_fresh_implies_consistent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fresh_o |-> consistent_o);

endmodule

// File: rtl/fresh_track.sv
module fresh_track #(
  parameter int unsigned WORDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WORDS-1:0] word_we_i,
  input  logic             use_i,
  input  logic             clear_i,
  output logic             fresh_o,
  output logic             consistent_o
);

  logic all_marked;
  logic some_marked;

  fresh_track_marks #(.WORDS(WORDS)) u_marks (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .word_we_i    (word_we_i),
    .use_i        (use_i),
    .clear_i      (clear_i),
    .all_marked_o (all_marked),
    .some_marked_o(some_marked)
  );

  fresh_track_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .use_i        (use_i),
    .all_marked_i (all_marked),
    .some_marked_i(some_marked),
    .fresh_o      (fresh_o),
    .consistent_o (consistent_o)
  );

  a_r2_full_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (&word_we_i)) |=> (fresh_o && consistent_o));
  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !use_i && (word_we_i == '0)) |=> ($stable(fresh_o) && $stable(consistent_o)));

endmodule

// File: tb/sim_fresh_track.sv
module sim_fresh_track;
  localparam int unsigned W = 8;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] we;
  logic         use_p;
  logic         clr;
  logic         fresh;
  logic         cons;

  int checks = 0;
  int errors = 0;

  // bench reference state
  logic [W-1:0] m_marks;
  logic         m_fresh;
  logic         m_cons;

  fresh_track #(.WORDS(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .word_we_i(we), .use_i(use_p), .clear_i(clr),
    .fresh_o(fresh), .consistent_o(cons)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic string tag_of(logic [W-1:0] w, logic u, logic c, logic [W-1:0] mk);
    logic [W-1:0] nx;
    nx = (u ? '0 : mk) | w;
    if (c) return "R7";
    if (&nx) return "R2";
    if (nx != '0) return (mk != '0 && !u) ? "R4" : "R3";
    if (u) return "R5";
    return "R8";
  endfunction

  task automatic model_step(logic [W-1:0] w, logic u, logic c);
    logic [W-1:0] nx;
    nx = (u ? '0 : m_marks) | w;
    if (c) begin
      m_marks = '0; m_fresh = 1'b0; m_cons = 1'b1;
    end else if (&nx) begin
      m_marks = '0; m_fresh = 1'b1; m_cons = 1'b1;
    end else if (nx != '0) begin
      m_marks = nx; m_fresh = 1'b0; m_cons = 1'b0;
    end else begin
      m_marks = '0;
      if (u) m_fresh = 1'b0;
    end
  endtask

  task automatic compare(string tag);
    checks++;
    if (fresh !== m_fresh || cons !== m_cons) begin
      errors++;
      $display("FAIL %s: fresh/consistent actual %b%b expected %b%b",
               tag, fresh, cons, m_fresh, m_cons);
    end
  endtask

  // drive at negedge, clock, check at next negedge
  task automatic cyc(logic [W-1:0] w, logic u, logic c);
    string t;
    t = tag_of(w, u, c, m_marks);
    we = w; use_p = u; clr = c;
    @(posedge clk);
    model_step(w, u, c);
    @(negedge clk);
    we = '0; use_p = 1'b0; clr = 1'b0;
    compare(t);
  endtask

  initial begin
    we = '0; use_p = 1'b0; clr = 1'b0; rst_n = 1'b0;
    m_marks = '0; m_fresh = 1'b0; m_cons = 1'b0;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2: single-cycle full write
    cyc('1, 1'b0, 1'b0);
    // R5: consume
    cyc('0, 1'b1, 1'b0);
    // R8: idle hold
    cyc('0, 1'b0, 1'b0);
    // R3, R4: ascending word by word
    for (int i = 0; i < W; i++) cyc(W'(1) << i, 1'b0, 1'b0);
    // R4: descending with a repeated word
    for (int i = W - 1; i >= 0; i--) begin
      cyc(W'(1) << i, 1'b0, 1'b0);
      if (i == 4) cyc(W'(1) << i, 1'b0, 1'b0);
    end
    // R6: partial, then consume together with upper half
    cyc(8'h0F, 1'b0, 1'b0);
    cyc(8'hF0, 1'b1, 1'b0);
    cyc(8'h0F, 1'b0, 1'b0);
    // R7: wipe mid-partial with use and writes
    cyc(8'h3C, 1'b0, 1'b0);
    cyc(8'hC3, 1'b1, 1'b1);
    cyc('0, 1'b0, 1'b0);
    cyc(8'hC3, 1'b0, 1'b0);
    // R7 then R2 full in two halves
    cyc('0, 1'b0, 1'b1);
    cyc(8'hAA, 1'b0, 1'b0);
    cyc(8'h55, 1'b0, 1'b0);
    cyc('1, 1'b0, 1'b1);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] w;
      int r;
      r = $urandom_range(0, 99);
      if (r < 40) w = '0;
      else if (r < 80) w = W'(1) << $urandom_range(0, W - 1);
      else if (r < 95) w = W'($urandom);
      else w = '1;
      cyc(w, ($urandom_range(0, 99) < 6), ($urandom_range(0, 99) < 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule